// File: doc/BRIEF.md
# Four-line tagged receive silo

This block is the receive half of a four-line serial controller. Each line's bit-level receiver hands it a parallel character, a one-cycle strobe, the received parity bit and a framing-error flag. The block holds one parameter set per line. This set covers receiver enable, 7- or 8-bit characters, parity enable and sense, stop-bit count and a speed code. The stored set is driven back out to the line receivers. Characters from enabled lines are masked to their configured length and checked for parity. Each one is then tagged with its line number and written into one shared 64-entry first-in first-out silo.

The host loads the parameters with single-line writes: one write word names the target line and carries the whole set for it. It drains the silo through a receive word that always shows the oldest entry, and it pops that entry with a one-cycle read strobe. A ready flag tells the host that at least one character is waiting. A controller clear flushes the silo and turns every receiver off.

Top module: `rx_silo_top`

## Requirements
- R1: The receive word `rbuf_o` is {bit15 valid, bit14 overrun, bit13 framing error, bit12 parity error, bits11:10 zero, bits9:8 source line, bits7:0 character}. It is all zero when the silo is empty.
- R2: `rdone_o` is high exactly when the silo holds at least one entry. A read strobe on an empty silo has no effect.
- R3: A write on `cfg_we_i` updates the line named by `cfg_data_i[1:0]` from the fields [2] enable, [3] 8-bit length (0 = 7-bit), [4] parity enable, [5] odd parity, [6] two stop bits and [10:7] speed code. `cfg_o[9*i +: 9]` shows line i as {speed[3:0], stop2, odd, parity enable, 8-bit, enable}, with enable at bit 0. The speed code is only stored.
- R4: A strobe on a line whose enable is clear stores nothing.
- R5: A 7-bit line stores the character with bit 7 forced to 0. An 8-bit line stores all 8 bits.
- R6: With parity enabled, the parity error flag is set when the count of ones over the configured data bits plus the parity bit is odd for even parity, or even for odd parity. With parity disabled, the flag is always 0.
- R7: The framing error input of a line is stored with its character.
- R8: Entries leave in arrival order. Each read strobe pops exactly one entry, and up to 64 entries are held.
- R9: A character that finds the silo full is dropped, and the overrun bit is set on the next word read out only.
- R10: Characters strobed in the same cycle on several lines are stored lowest line first.
- R11: `clr_i` empties the silo and clears the enable of every line, leaving the other fields unchanged. It takes priority over a same-cycle parameter write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Controller clear |
| cfg_we_i | input | 1 | Line parameter write strobe |
| cfg_data_i | input | 11 | Line parameter write word |
| cfg_o | output | 36 | Stored parameters of all lines, 9 bits per line |
| rx_valid_i | input | 4 | Per-line character strobe |
| rx_data_i | input | 32 | Per-line received byte, line i at [8*i +: 8] |
| rx_par_i | input | 4 | Per-line received parity bit |
| rx_ferr_i | input | 4 | Per-line framing error |
| rd_i | input | 1 | Pop the oldest entry |
| rbuf_o | output | 16 | Receive word of the oldest entry |
| rdone_o | output | 1 | Silo not empty |

## Verification
The assertions watch, on every cycle, several rules about the silo's occupancy and the clear. Occupancy never exceeds the depth, and a pop with no push lowers it by exactly one. A dropped character always leaves the overrun flag pending. A clear always leaves the silo empty and every receiver disabled. Only the bench scenarios can show what the stored words contain. These cover the masking of 7-bit characters, the parity result for each length, sense and parity-bit combination on every line, and the lowest-line-first order of simultaneous arrivals. They also cover the single word that carries the overrun mark after a 65-character burst.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned LINE_W  = 2;
  localparam int unsigned SPEED_W = 4;

  typedef struct packed {
    logic [SPEED_W-1:0] speed;
    logic               stop2;
    logic               odd;
    logic               par_en;
    logic               len8;
    logic               en;
  } line_cfg_t;

  typedef struct packed {
    logic [LINE_W-1:0] line;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_ent_t;
endpackage

// File: rtl/line_cfg_bank.sv
module line_cfg_bank
  import rxs_pkg::*;
#(
  parameter int unsigned NLINES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [10:0]       wdata_i,
  output line_cfg_t         cfg_o [NLINES]
);
  line_cfg_t wr_val;
  assign wr_val = '{speed: wdata_i[10:7], stop2: wdata_i[6], odd: wdata_i[5],
                    par_en: wdata_i[4], len8: wdata_i[3], en: wdata_i[2]};

  logic [NLINES-1:0] en_vec;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_o[i] <= '0;
      else if (clr_i) cfg_o[i].en <= 1'b0;
      else if (we_i && wdata_i[LINE_W-1:0] == LINE_W'(i)) cfg_o[i] <= wr_val;
    end
    assign en_vec[i] = cfg_o[i].en;
  end

  // R11
  clr_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> en_vec == '0);
endmodule

// File: rtl/rx_line_front.sv
module rx_line_front
  import rxs_pkg::*;
#(
  parameter int unsigned LINE = 0
) (
  input  line_cfg_t         cfg_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              ferr_i,
  output logic              push_o,
  output rx_ent_t           ent_o
);
  logic [DATA_W-1:0] masked;
  logic              ones_odd;

  assign masked   = cfg_i.len8 ? data_i : {1'b0, data_i[DATA_W-2:0]};
  assign ones_odd = ^masked ^ par_i;
  assign push_o   = valid_i & cfg_i.en;

  always_comb begin
    ent_o.line = LINE_W'(LINE);
    ent_o.ferr = ferr_i;
    ent_o.perr = cfg_i.par_en & (ones_odd != cfg_i.odd);
    ent_o.data = masked;
  end
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rxs_pkg::*;
#(
  parameter int unsigned NLINES = 4,
  parameter int unsigned DEPTH  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [NLINES-1:0] push_i,
  input  rx_ent_t           ent_i [NLINES],
  input  logic              pop_i,
  output rx_ent_t           head_o,
  output logic              nempty_o,
  output logic              ovr_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  rx_ent_t           mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt;
  logic [NLINES-1:0] wr_en;
  logic [AW-1:0]     wr_idx [NLINES];
  logic [CW-1:0]     nacc;
  logic              drop;
  logic              pop;

  // lower line index takes the lower slot
  always_comb begin
    nacc = '0;
    drop = 1'b0;
    for (int i = 0; i < NLINES; i++) begin
      wr_en[i]  = 1'b0;
      wr_idx[i] = wr_ptr + nacc[AW-1:0];
      if (push_i[i] && !clr_i) begin
        if (cnt + nacc < CW'(DEPTH)) begin
          wr_en[i] = 1'b1;
          nacc     = nacc + 1'b1;
        end else begin
          drop = 1'b1;
        end
      end
    end
  end

  assign pop      = pop_i && cnt != '0 && !clr_i;
  assign nempty_o = cnt != '0;
  assign head_o   = mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovr_o  <= 1'b0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovr_o  <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr + nacc[AW-1:0];
      rd_ptr <= rd_ptr + AW'(pop);
      cnt    <= cnt + nacc - CW'(pop);
      if (drop)     ovr_o <= 1'b1;
      else if (pop) ovr_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < NLINES; i++)
      if (wr_en[i]) mem[wr_idx[i]] <= ent_i[i];
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
  // R2
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && nempty_o && nacc == '0 && !clr_i) |=> cnt == $past(cnt) - 1'b1);
  // R9
  drop_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop && !clr_i) |=> ovr_o);
  // R11
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !nempty_o && !ovr_o);
endmodule

// File: rtl/rx_silo_top.sv
module rx_silo_top
  import rxs_pkg::*;
#(
  parameter int unsigned NLINES = 4,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned CFG_W = $bits(line_cfg_t)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     cfg_we_i,
  input  logic [10:0]              cfg_data_i,
  output logic [NLINES*CFG_W-1:0]  cfg_o,
  input  logic [NLINES-1:0]        rx_valid_i,
  input  logic [NLINES*DATA_W-1:0] rx_data_i,
  input  logic [NLINES-1:0]        rx_par_i,
  input  logic [NLINES-1:0]        rx_ferr_i,
  input  logic                     rd_i,
  output logic [15:0]              rbuf_o,
  output logic                     rdone_o
);
  line_cfg_t         cfg [NLINES];
  logic [NLINES-1:0] push;
  rx_ent_t           ent [NLINES];
  rx_ent_t           head;
  logic              nempty, ovr;

  line_cfg_bank #(.NLINES(NLINES)) i_cfg (
    .clk_i, .rst_ni, .clr_i,
    .we_i(cfg_we_i), .wdata_i(cfg_data_i), .cfg_o(cfg)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_front
    rx_line_front #(.LINE(i)) i_front (
      .cfg_i(cfg[i]), .valid_i(rx_valid_i[i]),
      .data_i(rx_data_i[DATA_W*i +: DATA_W]),
      .par_i(rx_par_i[i]), .ferr_i(rx_ferr_i[i]),
      .push_o(push[i]), .ent_o(ent[i])
    );
    assign cfg_o[CFG_W*i +: CFG_W] = cfg[i];
  end

  rx_silo #(.NLINES(NLINES), .DEPTH(DEPTH)) i_silo (
    .clk_i, .rst_ni, .clr_i,
    .push_i(push), .ent_i(ent), .pop_i(rd_i),
    .head_o(head), .nempty_o(nempty), .ovr_o(ovr)
  );

  assign rdone_o = nempty;
  assign rbuf_o  = nempty ? {1'b1, ovr, head.ferr, head.perr, 2'b00, head.line, head.data}
                          : 16'h0000;
endmodule

// File: tb/test_rx_silo_top.sv
`timescale 1ns/1ps
module test_rx_silo_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [10:0] cfg_data_i = '0;
  logic [35:0] cfg_o;
  logic [3:0]  rx_valid_i = '0;
  logic [31:0] rx_data_i = '0;
  logic [3:0]  rx_par_i = '0;
  logic [3:0]  rx_ferr_i = '0;
  logic        rd_i = 1'b0;
  logic [15:0] rbuf_o;
  logic        rdone_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  rx_silo_top i_rx_silo_top (.*);

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input logic ov, fe, pe, input int ln, input logic [7:0] d);
    return {1'b1, ov, fe, pe, 2'b00, 2'(ln), d};
  endfunction

  task automatic cfg(input int ln, input logic en, len8, pe, odd, st2, input logic [3:0] sp);
    cfg_data_i = {sp, st2, odd, pe, len8, en, 2'(ln)};
    cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic send(input logic [3:0] m, input logic [31:0] d, input logic [3:0] p, input logic [3:0] f);
    rx_valid_i = m; rx_data_i = d; rx_par_i = p; rx_ferr_i = f;
    @(negedge clk_i);
    rx_valid_i = '0;
  endtask

  task automatic pop_chk(input string req, input logic [15:0] exp);
    chk(req, 36'(rbuf_o), 36'(exp));
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2 reset rdone", 36'(rdone_o), 36'd0);
    chk("R1 reset rbuf", 36'(rbuf_o), 36'd0);
    chk("R3 reset cfg", cfg_o, 36'd0);

    // R3: distinct settings per line
    for (int l = 0; l < 4; l++) cfg(l, l[0], l[1], 1'b1, l[0], ~l[0], 4'(3 * l + 2));
    begin
      logic [35:0] e;
      for (int l = 0; l < 4; l++)
        e[9*l +: 9] = {4'(3 * l + 2), ~l[0], l[0], 1'b1, l[1], l[0]};
      chk("R3 cfg fields", cfg_o, e);
    end

    // R5 R6 R1: sweep lines, lengths, parity modes, data, parity bit
    for (int l = 0; l < 4; l++)
      for (int m = 0; m < 6; m++) begin
        logic len8, pe, odd;
        len8 = m[0]; pe = (m >> 1) != 0; odd = (m >> 1) == 2;
        cfg(l, 1'b1, len8, pe, odd, 1'b0, 4'hC);
        for (int k = 0; k < 5; k++)
          for (int p = 0; p < 2; p++) begin
            logic [7:0] d, ed;
            logic ep;
            int ones;
            d = (k == 0) ? 8'h00 : (k == 1) ? 8'hA5 : (k == 2) ? 8'h7F : (k == 3) ? 8'hFF : 8'h81;
            ed = len8 ? d : (d & 8'h7F);
            ones = $countones(ed) + p;
            ep = pe && ((ones % 2) != (odd ? 1 : 0));
            send(4'(1 << l), {4{d}}, {4{1'(p)}}, 4'h0);
            pop_chk("R5 R6 R1 sweep", word(1'b0, 1'b0, ep, l, ed));
          end
        cfg(l, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
      end

    // R7 framing flag
    cfg(2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h5);
    send(4'b0100, 32'h00_3C_00_00, 4'h0, 4'b0100);
    pop_chk("R7 framing", word(1'b0, 1'b1, 1'b0, 2, 8'h3C));

    // R4 disabled line discards
    send(4'b0010, 32'h0000_5500, 4'h0, 4'h0);
    chk("R4 disabled rdone", 36'(rdone_o), 36'd0);
    chk("R4 disabled rbuf", 36'(rbuf_o), 36'd0);

    // R10 simultaneous arrival
    for (int l = 0; l < 4; l++) cfg(l, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'h1);
    send(4'hF, 32'h44_33_22_11, 4'h0, 4'h0);
    for (int l = 0; l < 4; l++) pop_chk("R10 order", word(1'b0, 1'b0, 1'b0, l, 8'(8'h11 * (l + 1))));
    chk("R10 drained", 36'(rdone_o), 36'd0);

    // R8 R9 fill to 64, drop one more
    for (int i = 0; i < 65; i++) send(4'b0001, {24'h0, 8'(i)}, 4'h0, 4'h0);
    for (int i = 0; i < 64; i++) pop_chk(i < 2 ? "R9 overrun mark" : "R8 fifo order",
                                         word(i == 0, 1'b0, 1'b0, 0, 8'(i)));
    chk("R8 empty after 64", 36'(rdone_o), 36'd0);

    // R2 empty read ignored
    rd_i = 1'b1; @(negedge clk_i); rd_i = 1'b0;
    chk("R2 empty read", 36'(rbuf_o), 36'd0);
    send(4'b1000, 32'h9A00_0000, 4'h0, 4'h0);
    chk("R2 rdone set", 36'(rdone_o), 36'd1);
    pop_chk("R2 after empty read", word(1'b0, 1'b0, 1'b0, 3, 8'h9A));

    // R11 clear
    send(4'b0011, 32'h0000_2211, 4'h0, 4'h0);
    clr_i = 1'b1; cfg_data_i = 11'h7FD; cfg_we_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0; cfg_we_i = 1'b0;
    chk("R11 silo empty", 36'(rdone_o), 36'd0);
    begin
      logic [35:0] e;
      for (int l = 0; l < 4; l++) e[9*l +: 9] = {4'h1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      chk("R11 enables cleared", cfg_o, e);
    end
    send(4'hF, 32'h1234_5678, 4'h0, 4'h0);
    chk("R11 no capture", 36'(rbuf_o), 36'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule